// File: doc/BRIEF.md
# Bit-Serial Multiplierless Dot Product

This block forms the inner product of K constant coefficients with K signed input words, without a multiplier. Each input word is an N-bit two's complement value. All K words arrive together, one bit per clock, least-significant bit first, with one serial lane per word. At each bit time the K lane bits form an address into a table. Entry `a` of that table holds the sum of every coefficient whose lane bit is set in `a`. The table is computed at elaboration from the coefficient parameter.

A scaling accumulator shifts its running sum right by one each slice, then adds the aligned table word. On the slice flagged by the sign-time marker it subtracts the table word instead. After N slices the accumulator holds the exact integer dot product, and the block presents that value on a registered output with a one-cycle valid pulse. A start strobe marks the first slice of each vector. The next vector may begin in the cycle right after a sign slice.

Top module: `da_dot_serial`

## Requirements
- R1: While reset is asserted, and after it is released with no vector taken, `res_vld_o` is 0 and `res_o` is 0.
- R2: Bit k of `bits_i` is the current bit of input word k (lane k). The table word selected by `bits_i` equals the sum of the coefficients whose lane bit is 1. A vector with word k equal to 1 and all other words 0 yields coefficient k.
- R3: A cycle with `start_i` high carries the least-significant slice of a new vector. The accumulator discards any earlier sum in that cycle.
- R4: Slices arrive least-significant first. `sign_i` is high on the N-th slice, which holds the sign bits. In every slice, the earlier sum is arithmetically shifted right by one before the table word, aligned at weight 2^(N-1), is combined with it.
- R5: On the slice with `sign_i` high, the table word is subtracted. On every other slice it is added.
- R6: `res_o` equals the exact integer sum of coefficient k times word k. This holds for every input value, including the most negative one, and no intermediate sum overflows the accumulator.
- R7: `res_vld_o` is high for exactly one cycle: the cycle right after the sign slice of a vector that was taken. Between pulses, `res_o` holds its last value.
- R8: A start strobe in the cycle right after a sign slice is accepted. The vectors then follow each other with no idle cycle.
- R9: A slice in which no vector is in progress and `start_i` is low has no effect. No valid pulse follows and `res_o` is unchanged, even if `sign_i` is high.
- R10: A start strobe while a vector is still in progress abandons that vector. Only the new vector's result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | First (least-significant) slice of a new vector |
| bits_i | input | K | Current bit of each input word, lane k in bit k |
| sign_i | input | 1 | High on the sign-bit slice |
| res_o | output | M+N+clog2(K)+1 | Signed dot product, registered |
| res_vld_o | output | 1 | One-cycle pulse when `res_o` carries a new result |

## Verification
Two functions can fall in the same cycle: the output of one vector's result, and the clearing first slice of the next vector. Back-to-back runs of random vectors provoke this. So do start strobes placed mid-vector, where a restart meets a running sum. A behavioural model in the bench tracks the expected valid flag and the expected held result on every clock. It computes the result as an integer dot product. Any stale partial sum leaking into the next result, or a lost or doubled valid pulse, therefore shows up at the ports.

// File: rtl/da_pkg.sv
package da_pkg;

  typedef enum logic {
    SLC_IDLE = 1'b0,
    SLC_RUN  = 1'b1
  } slc_state_e;

  function automatic int unsigned da_tbl_width(int unsigned m, int unsigned k);
    return m + $clog2(k);
  endfunction

  function automatic int unsigned da_acc_width(int unsigned m, int unsigned n,
                                               int unsigned k);
    return m + n + $clog2(k) + 1;
  endfunction

endpackage

// File: rtl/da_coef_table.sv
module da_coef_table
  import da_pkg::*;
#(
  parameter int unsigned K = 4,
  parameter int unsigned M = 8,
  parameter logic [K*M-1:0] COEFS = '0
) (
  input  logic [K-1:0]                              addr_i,
  output logic signed [da_tbl_width(M, K)-1:0]      word_o
);

  localparam int unsigned TW    = da_tbl_width(M, K);
  localparam int unsigned DEPTH = 1 << K;

  // Sum of the coefficients selected by the set bits of addr.
  function automatic logic signed [TW-1:0] entry_sum(int unsigned addr);
    logic signed [TW-1:0] s;
    s = '0;
    for (int k = 0; k < K; k++) begin
      if (addr[k]) s = s + TW'(signed'(COEFS[k*M +: M]));
    end
    return s;
  endfunction

  logic signed [TW-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    assign tbl[a] = entry_sum(a);
  end

  assign word_o = tbl[addr_i];

endmodule

// File: rtl/da_slice_ctrl.sv
module da_slice_ctrl
  import da_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sign_i,
  output logic take_o,
  output logic clr_o,
  output logic last_o
);

  localparam int unsigned CW = $clog2(N) + 1;

  slc_state_e      state_q, state_nxt;
  logic [CW-1:0]   cnt_q, cnt_nxt;
  logic            cnt_en;

  assign take_o = start_i || (state_q == SLC_RUN);
  assign clr_o  = start_i;
  assign last_o = take_o && sign_i;

  always_comb begin
    state_nxt = state_q;
    if (last_o)       state_nxt = SLC_IDLE;
    else if (start_i) state_nxt = SLC_RUN;
  end

  assign cnt_en = take_o;

  always_comb begin
    cnt_nxt = cnt_q;
    if (last_o)       cnt_nxt = '0;
    else if (start_i) cnt_nxt = CW'(1);
    else              cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLC_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      if (cnt_en) cnt_q <= cnt_nxt;
    end
  end

  AST_SIGN_ON_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLC_RUN && sign_i && !start_i) |-> (cnt_q == CW'(N - 1))); // R4

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(N)); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !sign_i) |=> (state_q == SLC_RUN && cnt_q == CW'(1))); // R10

endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc
  import da_pkg::*;
#(
  parameter int unsigned K = 4,
  parameter int unsigned M = 8,
  parameter int unsigned N = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     en_i,
  input  logic                                     clr_i,
  input  logic                                     sub_i,
  input  logic signed [da_tbl_width(M, K)-1:0]     word_i,
  output logic signed [da_acc_width(M, N, K)-1:0]  sum_nxt_o
);

  localparam int unsigned TW = da_tbl_width(M, K);
  localparam int unsigned AW = da_acc_width(M, N, K);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] base, shifted, aligned;
  logic signed [AW:0]   wide;

  always_comb begin
    base      = clr_i ? '0 : acc_q;
    shifted   = base >>> 1;
    aligned   = AW'(word_i) <<< (N - 1);
    sum_nxt_o = sub_i ? (shifted - aligned) : (shifted + aligned);
  end

  // One extra bit to observe whether the AW-bit result wrapped.
  assign wide = sub_i ? ((AW+1)'(shifted) - (AW+1)'(aligned))
                      : ((AW+1)'(shifted) + (AW+1)'(aligned));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en_i) begin
      acc_q <= sum_nxt_o;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (wide[AW] == wide[AW-1])); // R6

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(acc_q)); // R9

  AST_TW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (aligned >>> (N - 1)) == AW'(word_i)); // R4

endmodule

// File: rtl/da_dot_serial.sv
module da_dot_serial
  import da_pkg::*;
#(
  parameter int unsigned K = 4,
  parameter int unsigned N = 8,
  parameter int unsigned M = 8,
  parameter logic [K*M-1:0] COEFS = 32'h807F_D325
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [K-1:0]                   bits_i,
  input  logic                           sign_i,
  output logic signed [M+N+$clog2(K):0]  res_o,
  output logic                           res_vld_o
);

  localparam int unsigned TW = da_tbl_width(M, K);
  localparam int unsigned AW = da_acc_width(M, N, K);

  logic                 take_w, clr_w, last_w;
  logic signed [TW-1:0] word_w;
  logic signed [AW-1:0] sum_nxt_w;
  logic signed [AW-1:0] res_q, res_nxt;
  logic                 vld_q, vld_nxt;

  da_slice_ctrl #(.N(N)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .sign_i  (sign_i),
    .take_o  (take_w),
    .clr_o   (clr_w),
    .last_o  (last_w)
  );

  da_coef_table #(.K(K), .M(M), .COEFS(COEFS)) tbl_i (
    .addr_i (bits_i),
    .word_o (word_w)
  );

  da_scale_acc #(.K(K), .M(M), .N(N)) acc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (take_w),
    .clr_i     (clr_w),
    .sub_i     (sign_i),
    .word_i    (word_w),
    .sum_nxt_o (sum_nxt_w)
  );

  always_comb begin
    vld_nxt = last_w;
    res_nxt = last_w ? sum_nxt_w : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign res_o     = res_q;
  assign res_vld_o = vld_q;

  AST_VLD_AFTER_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && sign_i) |=> res_vld_o); // R7

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((N > 1) && res_vld_o) |=> !res_vld_o); // R7

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> $stable(res_o)); // R7

  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> (!res_vld_o && $stable(res_o))); // R9

endmodule

// File: tb/da_dot_serial_tb.sv
module da_dot_serial_tb_top;

  localparam int unsigned K = 4;
  localparam int unsigned N = 8;
  localparam int unsigned M = 8;
  localparam logic [K*M-1:0] COEFS = 32'h807F_D325;
  localparam int unsigned AW = M + N + $clog2(K) + 1;
  localparam time CLK_PERIOD = 10ns;

  logic                 clk;
  logic                 rst_n;
  logic                 start_i;
  logic [K-1:0]         bits_i;
  logic                 sign_i;
  logic signed [AW-1:0] res_o;
  logic                 res_vld_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  // Behavioural model state.
  bit     exp_vld = 0;
  longint exp_res = 0;
  string  exp_tag = "R1";
  bit     m_busy  = 0;
  longint m_dot   = 0;

  da_dot_serial #(.K(K), .N(N), .M(M), .COEFS(COEFS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .bits_i    (bits_i),
    .sign_i    (sign_i),
    .res_o     (res_o),
    .res_vld_o (res_vld_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired after %0d cycles (actual hung, expected finish)", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic longint coef(int k);
    return longint'(signed'(COEFS[k*M +: M]));
  endfunction

  task automatic check(string tag, longint act, longint expv, string what);
    total = total + 1;
    if (act != expv) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Compare outputs from the previous slice, then drive the next slice.
  task automatic step(bit st, logic [K-1:0] b, bit s, string tag);
    @(negedge clk);
    check(exp_vld ? exp_tag : "R7", longint'(res_vld_o), longint'(exp_vld), "res_vld_o");
    check(exp_tag, longint'(res_o), exp_res, "res_o");
    start_i = st;
    bits_i  = b;
    sign_i  = s;
    if (st) m_busy = 1;
    if (m_busy && s) begin
      exp_vld = 1;
      exp_res = m_dot;
      exp_tag = tag;
      m_busy  = 0;
    end else begin
      exp_vld = 0;
      if (!exp_vld) exp_tag = exp_tag;
    end
  endtask

  task automatic send_vec(int xs[K], int slices, string tag);
    longint d = 0;
    for (int k = 0; k < K; k++) d += coef(k) * longint'(xs[k]);
    m_dot = d;
    for (int j = 0; j < slices; j++) begin
      logic [K-1:0] b;
      for (int k = 0; k < K; k++) b[k] = ((xs[k] >>> j) & 1) != 0;
      step(j == 0, b, j == N - 1, tag);
    end
  endtask

  task automatic idle(int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      logic [K-1:0] b;
      b = K'($urandom);
      step(1'b0, b, 1'($urandom), tag);
    end
  endtask

  function automatic int rnd_word();
    return int'(signed'(N'($urandom)));
  endfunction

  initial begin
    int xs[K];
    start_i = 0;
    bits_i  = '0;
    sign_i  = 0;
    rst_n   = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", longint'(res_vld_o), 0, "res_vld_o in reset");
    check("R1", longint'(res_o), 0, "res_o in reset");
    rst_n = 1;
    idle(2, "R1");

    // R2: one lane set to 1 selects a single coefficient.
    for (int k = 0; k < K; k++) begin
      for (int i = 0; i < K; i++) xs[i] = (i == k) ? 1 : 0;
      send_vec(xs, N, "R2");
      idle(1, "R2");
    end
    // R5: all ones in every lane hits the full-sum entry on the sign slice.
    for (int i = 0; i < K; i++) xs[i] = -1;
    send_vec(xs, N, "R5");
    idle(2, "R5");
    // R6: most negative and most positive words.
    for (int i = 0; i < K; i++) xs[i] = -(1 << (N - 1));
    send_vec(xs, N, "R6");
    for (int i = 0; i < K; i++) xs[i] = (i % 2 == 0) ? -(1 << (N - 1)) : (1 << (N - 1)) - 1;
    send_vec(xs, N, "R6");
    // R4: single high bit per lane at different weights.
    for (int i = 0; i < K; i++) xs[i] = 1 << (i + 2);
    send_vec(xs, N, "R4");
    idle(3, "R9");
    // R8: back-to-back random vectors, new start right after each sign slice.
    for (int v = 0; v < 40; v++) begin
      for (int i = 0; i < K; i++) xs[i] = rnd_word();
      send_vec(xs, N, "R8");
    end
    // R9: idle slices with random bits and sign marker.
    idle(12, "R9");
    // R10: abandon a vector part way, then restart.
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < K; i++) xs[i] = rnd_word();
      send_vec(xs, 2 + v % 5, "R10");
      for (int i = 0; i < K; i++) xs[i] = rnd_word();
      send_vec(xs, N, "R10");
      idle(v % 3, "R9");
    end
    // R3: start clears a stale sum after gaps of different length.
    for (int v = 0; v < 10; v++) begin
      for (int i = 0; i < K; i++) xs[i] = rnd_word();
      send_vec(xs, N, "R3");
      idle(v % 4, "R9");
    end
    idle(2, "R7");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule